// File: doc/BRIEF.md
# Carrier Offset Sign Resolver

A mixer that beats a received carrier against a nominal oscillator yields the size of the frequency offset but not its direction. This block settles the direction. On a start pulse it records a fixed window of signed ADC samples into on-chip memory. It then replays that same record twice through an internal oscillator, which is built from a phase accumulator and a sine table. The first replay runs at the nominal tuning word plus the offset word. The second runs at the nominal word minus the offset word.

During each replay, the stored samples are multiplied by the oscillator output. The product is smoothed by a short moving average, and the block sums how much the smoothed value moves from sample to sample. A trial frequency that matches the carrier leaves an almost constant product, so its sum is small. A wrong trial leaves a beat at twice the offset, so its sum is large. The trial with the smaller sum gives the output tuning word, and a flag records which sign won. The result stays on the outputs until the next start.

The default tuning word for the nominal oscillator is 0x10000000, which is one sixteenth of the sample rate.

Top module: `offset_sign_resolver`

## Requirements
- R1: While reset is held and after it is released, `done` is 0, `tuning_word` is 0 and `offset_negative` is 0.
- R2: A start pulse arms a capture of the next 1024 samples presented with `sample_valid` high. Cycles with `sample_valid` low are skipped without advancing the write position. Samples presented outside the capture window are ignored.
- R3: The oscillator table is indexed by the top 8 bits of a 32-bit phase. For index p, let h = p mod 128 and m = h*(128-h). The entry is +m for p < 128 and -m otherwise. In each replay, stored sample k (counting from 0) is multiplied by the entry for phase k*TW mod 2^32, and the product is shifted arithmetically right by 12.
- R4: For each replay, the window of the last 16 mixed values starts as all zeros, and the previous average starts at 0. For each sample the average is the window sum shifted arithmetically right by 4. The replay error is the sum of |average − previous average| over all 1024 samples.
- R5: The first replay uses TW = nominal + offset and the second uses TW = nominal − offset, both modulo 2^32. Both words are taken from the inputs in the cycle the start pulse is accepted, and later changes to those inputs have no effect on the run.
- R6: When the decision is made, `offset_negative` = 1 and `tuning_word` = nominal − offset if the minus error is strictly smaller than the plus error. Otherwise `offset_negative` = 0 and `tuning_word` = nominal + offset.
- R7: When the two errors are equal, the plus candidate is chosen (`offset_negative` = 0).
- R8: Each replay's error accumulator is 32 bits wide and saturates at 2^32−1. It never decreases during a replay.
- R9: `done` is 0 from the cycle after an accepted start until the decision is made. It then stays at 1 until the next accepted start, rising no later than 2*1024+40 cycles after the last captured sample. `tuning_word` and `offset_negative` keep their earlier values until the decision is made.
- R10: A start pulse during capture or during either replay is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins capture when the block is idle or done |
| sample_valid | input | 1 | Qualifies `sample_in` |
| sample_in | input | 12 | Signed ADC sample |
| nominal_tw | input | 32 | Nominal oscillator tuning word |
| offset_tw | input | 32 | Magnitude of the estimated offset as a tuning word |
| tuning_word | output | 32 | Chosen tuning word |
| offset_negative | output | 1 | 1 when the minus candidate was chosen |
| done | output | 1 | Decision available |

## Verification
The assertions rely on several properties of the inputs:
- `start` is a single-cycle pulse.
- `sample_valid` means nothing outside the capture window.
- The error accumulators begin each replay from zero, so monotonic growth is checked only between clears.

The stimulus follows these rules:
- It pulses start for one cycle.
- It inserts idle cycles inside a capture.
- It keeps synthesized samples within ±2047.
- It deliberately presents extra samples, a stray start and changed tuning inputs while the replays run, to show that they are ignored.

// File: rtl/osr_pkg.sv
package osr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CAPTURE = 3'd1,
      ST_PASS_P  = 3'd2,
      ST_PASS_M  = 3'd3,
      ST_DECIDE  = 3'd4,
      ST_DONE    = 3'd5
   } osr_state_t;

endpackage

// File: rtl/osr_sample_ram.sv
module osr_sample_ram #(
   parameter int DATA_W = 12,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/osr_sine_rom.sv
module osr_sine_rom #(
   parameter int LUT_BITS = 8,
   localparam int LUT_W   = 2 * (LUT_BITS - 1) + 1
) (
   input  logic [LUT_BITS-1:0]     idx,
   output logic signed [LUT_W-1:0] val
);
   localparam int ROM_LEN = 1 << LUT_BITS;
   localparam int HALF    = 1 << (LUT_BITS - 1);

   function automatic logic signed [LUT_W-1:0] entry(input int p);
      int h;
      int m;
      h = p % HALF;
      m = h * (HALF - h);
      return (p >= HALF) ? LUT_W'(-m) : LUT_W'(m);
   endfunction

   logic signed [LUT_W-1:0] tab [ROM_LEN];

   for (genvar g = 0; g < ROM_LEN; g++) begin : g_tab
      assign tab[g] = entry(g);
   end

   assign val = tab[idx];
endmodule

// File: rtl/osr_residual_meter.sv
module osr_residual_meter #(
   parameter int SAMPLE_W   = 12,
   parameter int TW_W       = 32,
   parameter int DEPTH_LOG2 = 10,
   parameter int LUT_BITS   = 8,
   parameter int AVG_LOG2   = 4,
   parameter int ERR_W      = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [TW_W-1:0]       tw,
   output logic                  rd_en,
   output logic [DEPTH_LOG2-1:0] rd_addr,
   input  logic [SAMPLE_W-1:0]   rd_data,
   output logic [ERR_W-1:0]      err,
   output logic                  fin
);
   localparam int DEPTH   = 1 << DEPTH_LOG2;
   localparam int LUT_W   = 2 * (LUT_BITS - 1) + 1;
   localparam int MIX_SH  = 2 * (LUT_BITS - 1) - 2;
   localparam int PROD_W  = SAMPLE_W + LUT_W;
   localparam int MIX_W   = SAMPLE_W + 2;
   localparam int AVG_LEN = 1 << AVG_LOG2;
   localparam int SUM_W   = MIX_W + AVG_LOG2 + 1;
   localparam logic [DEPTH_LOG2-1:0] LAST = DEPTH_LOG2'(DEPTH - 1);

   // issue stage: phase accumulator and read address
   logic                  running;
   logic [DEPTH_LOG2-1:0] idx;
   logic [TW_W-1:0]       ph, tw_q;
   logic                  p1_v, p1_last;
   logic [TW_W-1:0]       p1_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         idx     <= '0;
         ph      <= '0;
         tw_q    <= '0;
         p1_v    <= 1'b0;
         p1_last <= 1'b0;
         p1_ph   <= '0;
      end else if (start) begin
         running <= 1'b1;
         idx     <= '0;
         ph      <= '0;
         tw_q    <= tw;
         p1_v    <= 1'b0;
         p1_last <= 1'b0;
      end else begin
         p1_v    <= running;
         p1_last <= running && (idx == LAST);
         p1_ph   <= ph;
         if (running) begin
            idx <= idx + 1'b1;
            ph  <= ph + tw_q;
            if (idx == LAST) running <= 1'b0;
         end
      end
   end

   assign rd_en   = running;
   assign rd_addr = idx;

   // mix stage
   logic signed [LUT_W-1:0]  lut_val;
   logic signed [PROD_W-1:0] prod, prod_sh;
   logic signed [MIX_W-1:0]  p2_mix;
   logic                     p2_v, p2_last;

   osr_sine_rom #(.LUT_BITS(LUT_BITS)) u_rom (
      .idx (p1_ph[TW_W-1 -: LUT_BITS]),
      .val (lut_val)
   );

   assign prod    = $signed(rd_data) * lut_val;
   assign prod_sh = prod >>> MIX_SH;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p2_v    <= 1'b0;
         p2_last <= 1'b0;
         p2_mix  <= '0;
      end else if (start) begin
         p2_v    <= 1'b0;
         p2_last <= 1'b0;
      end else begin
         p2_v    <= p1_v;
         p2_last <= p1_last;
         p2_mix  <= prod_sh[MIX_W-1:0];
      end
   end

   // moving-average stage
   logic signed [MIX_W-1:0] win [AVG_LEN];
   logic signed [SUM_W-1:0] sum;
   logic                    p3_v, p3_last;

   for (genvar i = 0; i < AVG_LEN; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            win[i] <= '0;
         else if (start)        win[i] <= '0;
         else if (p2_v) begin
            if (i == 0)         win[i] <= p2_mix;
            else                win[i] <= win[(i > 0) ? i - 1 : 0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum     <= '0;
         p3_v    <= 1'b0;
         p3_last <= 1'b0;
      end else if (start) begin
         sum     <= '0;
         p3_v    <= 1'b0;
         p3_last <= 1'b0;
      end else begin
         p3_v    <= p2_v;
         p3_last <= p2_last;
         if (p2_v) sum <= sum + SUM_W'(p2_mix) - SUM_W'(win[AVG_LEN-1]);
      end
   end

   // residual accumulation stage
   logic signed [SUM_W-1:0] avg, prev_avg;
   logic signed [SUM_W:0]   diff;
   logic [SUM_W:0]          mag;
   logic [ERR_W:0]          acc_n;

   assign avg   = sum >>> AVG_LOG2;
   assign diff  = (SUM_W+1)'(avg) - (SUM_W+1)'(prev_avg);
   assign mag   = diff[SUM_W] ? (SUM_W+1)'(-diff) : (SUM_W+1)'(diff);
   assign acc_n = {1'b0, err} + (ERR_W+1)'(mag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err      <= '0;
         prev_avg <= '0;
         fin      <= 1'b0;
      end else if (start) begin
         err      <= '0;
         prev_avg <= '0;
         fin      <= 1'b0;
      end else begin
         fin <= p3_v && p3_last;
         if (p3_v) begin
            prev_avg <= avg;
            err      <= acc_n[ERR_W] ? {ERR_W{1'b1}} : acc_n[ERR_W-1:0];
         end
      end
   end

   // R8: the accumulator only grows within a replay
   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (p3_v && !start) |=> (err >= $past(err)))
      else $error("residual accumulator decreased");
endmodule

// File: rtl/offset_sign_resolver.sv
module offset_sign_resolver
   import osr_pkg::*;
#(
   parameter int SAMPLE_W   = 12,
   parameter int TW_W       = 32,
   parameter int DEPTH_LOG2 = 10,
   parameter int LUT_BITS   = 8,
   parameter int AVG_LOG2   = 4,
   parameter int ERR_W      = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                sample_valid,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic [TW_W-1:0]     nominal_tw,
   input  logic [TW_W-1:0]     offset_tw,
   output logic [TW_W-1:0]     tuning_word,
   output logic                offset_negative,
   output logic                done
);
   localparam int DEPTH = 1 << DEPTH_LOG2;
   localparam logic [DEPTH_LOG2-1:0] LAST = DEPTH_LOG2'(DEPTH - 1);

   if (SAMPLE_W < 4)                  begin : g_bad_sw  $error("SAMPLE_W too small"); end
   if (LUT_BITS < 3 || LUT_BITS > 12) begin : g_bad_lut $error("LUT_BITS out of range"); end
   if (TW_W < LUT_BITS)               begin : g_bad_tw  $error("TW_W below LUT_BITS"); end
   if (DEPTH_LOG2 < 2)                begin : g_bad_dep $error("DEPTH_LOG2 too small"); end
   if (AVG_LOG2 < 1)                  begin : g_bad_avg $error("AVG_LOG2 too small"); end

   osr_state_t            st;
   logic [DEPTH_LOG2-1:0] wr_idx;
   logic [TW_W-1:0]       nom_q, off_q, tw_q, tw_plus, tw_minus, m_tw;
   logic                  neg_q, m_start, m_rd_en, m_fin, wr_en;
   logic [DEPTH_LOG2-1:0] m_rd_addr;
   logic [SAMPLE_W-1:0]   rd_data;
   logic [ERR_W-1:0]      m_err, err_p, err_m;

   assign tw_plus  = nom_q + off_q;
   assign tw_minus = nom_q - off_q;
   assign m_tw     = (st == ST_PASS_M) ? tw_minus : tw_plus;
   assign wr_en    = (st == ST_CAPTURE) && sample_valid;

   osr_sample_ram #(.DATA_W(SAMPLE_W), .ADDR_W(DEPTH_LOG2)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_idx),
      .wdata (sample_in),
      .re    (m_rd_en),
      .raddr (m_rd_addr),
      .rdata (rd_data)
   );

   osr_residual_meter #(
      .SAMPLE_W   (SAMPLE_W),
      .TW_W       (TW_W),
      .DEPTH_LOG2 (DEPTH_LOG2),
      .LUT_BITS   (LUT_BITS),
      .AVG_LOG2   (AVG_LOG2),
      .ERR_W      (ERR_W)
   ) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (m_start),
      .tw      (m_tw),
      .rd_en   (m_rd_en),
      .rd_addr (m_rd_addr),
      .rd_data (rd_data),
      .err     (m_err),
      .fin     (m_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         wr_idx  <= '0;
         nom_q   <= '0;
         off_q   <= '0;
         tw_q    <= '0;
         neg_q   <= 1'b0;
         err_p   <= '0;
         err_m   <= '0;
         m_start <= 1'b0;
      end else begin
         m_start <= 1'b0;
         case (st)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  nom_q  <= nominal_tw;
                  off_q  <= offset_tw;
                  wr_idx <= '0;
                  st     <= ST_CAPTURE;
               end
            end
            ST_CAPTURE: begin
               if (sample_valid) begin
                  wr_idx <= wr_idx + 1'b1;
                  if (wr_idx == LAST) begin
                     st      <= ST_PASS_P;
                     m_start <= 1'b1;
                  end
               end
            end
            ST_PASS_P: begin
               if (m_fin) begin
                  err_p   <= m_err;
                  st      <= ST_PASS_M;
                  m_start <= 1'b1;
               end
            end
            ST_PASS_M: begin
               if (m_fin) begin
                  err_m <= m_err;
                  st    <= ST_DECIDE;
               end
            end
            ST_DECIDE: begin
               if (err_m < err_p) begin
                  tw_q  <= tw_minus;
                  neg_q <= 1'b1;
               end else begin
                  tw_q  <= tw_plus;
                  neg_q <= 1'b0;
               end
               st <= ST_DONE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign tuning_word     = tw_q;
   assign offset_negative = neg_q;
   assign done            = (st == ST_DONE);

   // R2: a skipped cycle leaves the write position alone
   assert_capture_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CAPTURE && !sample_valid) |=> $stable(wr_idx))
      else $error("write position moved without a sample");

   // R6: the flag names the candidate with the lower error
   assert_pick_lower_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE) |-> (neg_q ? (err_m < err_p) : (err_p <= err_m)))
      else $error("chosen candidate does not have the lower error");

   // R7: equal errors favour the plus candidate
   assert_tie_plus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE && err_p == err_m) |-> !neg_q)
      else $error("tie did not select plus candidate");

   // R9: results move only on the decision cycle
   assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_DECIDE) |=> ($stable(tw_q) && $stable(neg_q)))
      else $error("result changed outside decision");

   // R10: a start during a replay does not restart capture
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_PASS_P || st == ST_PASS_M) && start) |=> (st != ST_CAPTURE))
      else $error("start accepted during a replay");
endmodule

// File: tb/tb_offset_sign_resolver.sv
`timescale 1ns/1ps
module tb_offset_sign_resolver;
   localparam int DEPTH = 1024;
   localparam int BOUND = 2 * DEPTH + 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sample_valid = 1'b0;
   logic [11:0] sample_in = '0;
   logic [31:0] nominal_tw = '0;
   logic [31:0] offset_tw = '0;
   logic [31:0] tuning_word;
   logic        offset_negative;
   logic        done;

   int compared = 0;
   int mismatched = 0;

   logic [31:0] old_tw = '0, new_tw = '0;
   logic        old_sign = 1'b0, new_sign = 1'b0;
   bit          cap_busy = 1'b0;
   bit          mon_on = 1'b0;
   int          stim [$];

   always #10 clk = ~clk;

   offset_sign_resolver dut (
      .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
      .sample_in(sample_in), .nominal_tw(nominal_tw), .offset_tw(offset_tw),
      .tuning_word(tuning_word), .offset_negative(offset_negative), .done(done)
   );

   function automatic int lutf(input int p);
      int h;
      h = p % 128;
      return (p >= 128) ? -(h * (128 - h)) : h * (128 - h);
   endfunction

   // R3 R4 R8: behavioural residual of one replay
   function automatic longint residual(input logic [31:0] tw);
      longint win [$];
      longint sum, avg, prev, err, m;
      logic [31:0] ph;
      sum = 0; prev = 0; err = 0; ph = '0;
      for (int i = 0; i < 16; i++) win.push_back(0);
      for (int k = 0; k < DEPTH; k++) begin
         m = (longint'(stim[k]) * longint'(lutf(int'(ph[31:24])))) >>> 12;
         sum = sum + m - win.pop_back();
         win.push_front(m);
         avg = sum >>> 4;
         err = err + ((avg > prev) ? avg - prev : prev - avg);
         if (err > 64'hFFFF_FFFF) err = 64'hFFFF_FFFF;
         prev = avg;
         ph = ph + tw;
      end
      return err;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model, sampled mid high phase
   always @(posedge clk) begin
      #5;
      if (mon_on) begin
         if (done) begin
            check(tuning_word == new_tw, "R6 word", tuning_word, new_tw);
            check(offset_negative == new_sign, "R6 sign", offset_negative, new_sign);
            check(!cap_busy, "R9 early done", done, 0);
         end else begin
            check(tuning_word == old_tw, "R9 hold word", tuning_word, old_tw);
            check(offset_negative == old_sign, "R9 hold sign", offset_negative, old_sign);
         end
      end
   end

   task automatic run_case(input logic [31:0] nom, input logic [31:0] off,
                           input logic [31:0] true_tw, input bit gaps, input bit disturb);
      logic [31:0] ph;
      logic [31:0] tp, tm;
      longint ep, em;
      int wait_n;
      stim.delete();
      ph = '0;
      for (int k = 0; k < DEPTH; k++) begin
         stim.push_back((lutf(int'(ph[31:24])) * 511) / 1024 + ((k * 37) % 7) - 3);
         ph = ph + true_tw;
      end
      tp = nom + off;
      tm = nom - off;
      ep = residual(tp);
      em = residual(tm);
      @(negedge clk);
      nominal_tw = nom;
      offset_tw  = off;
      start      = 1'b1;
      @(posedge clk);
      #1;
      cap_busy = 1'b1;
      new_tw   = (em < ep) ? tm : tp;        // R6, R7 tie to plus
      new_sign = (em < ep);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         if (gaps && (k % 5 == 2)) begin
            sample_valid = 1'b0;
            sample_in    = 12'h7FF;           // R2: not captured
            @(negedge clk);
         end
         if (disturb && k == 300) start = 1'b1;   // R10: ignored during capture
         sample_valid = 1'b1;
         sample_in    = stim[k][11:0];
         @(negedge clk);
         start = 1'b0;
      end
      cap_busy = 1'b0;
      sample_valid = 1'b0;
      wait_n = 0;
      while (!done && wait_n <= BOUND) begin
         if (disturb && wait_n < 60) begin
            sample_valid = 1'b1;              // R2: outside window, ignored
            sample_in    = 12'h5A5;
            nominal_tw   = 32'hDEAD_BEEF;     // R5: latched, no effect
            offset_tw    = 32'h0BAD_F00D;
            start        = (wait_n == 30 || wait_n == 1500); // R10
         end else begin
            sample_valid = 1'b0;
            start        = 1'b0;
         end
         @(negedge clk);
         wait_n++;
      end
      start = 1'b0;
      sample_valid = 1'b0;
      check(wait_n <= BOUND, "R9 latency", wait_n, BOUND);
      check(done == 1'b1, "R9 done", done, 1);
      repeat (5) @(negedge clk);
      check(done == 1'b1, "R9 done held", done, 1);
      check(tuning_word == new_tw, "R3 R4 R5 R8 word", tuning_word, new_tw);
      old_tw   = new_tw;
      old_sign = new_sign;
   endtask

   initial begin
      #(200000 * 20);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done in reset", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done == 1'b0, "R1 done", done, 0);
      check(tuning_word == 32'h0, "R1 word", tuning_word, 0);
      check(offset_negative == 1'b0, "R1 sign", offset_negative, 0);
      mon_on = 1'b1;
      // R6: carrier above nominal
      run_case(32'h1000_0000, 32'h0100_0000, 32'h1100_0000, 1'b0, 1'b0);
      check(new_sign == 1'b0, "R6 plus case", new_sign, 0);
      // R6: carrier below nominal, with capture gaps (R2)
      run_case(32'h1000_0000, 32'h0100_0000, 32'h0F00_0000, 1'b1, 1'b0);
      check(new_sign == 1'b1, "R6 minus case", new_sign, 1);
      // R7: zero offset gives equal errors
      run_case(32'h1000_0000, 32'h0000_0000, 32'h1000_0000, 1'b0, 1'b0);
      check(offset_negative == 1'b0, "R7 tie", offset_negative, 0);
      // R10 R5 R2: stray start, changed words and extra samples while busy
      run_case(32'h1000_0000, 32'h0080_0000, 32'h0F80_0000, 1'b1, 1'b1);
      // R5: other nominal, wrap-around of minus word
      run_case(32'h0040_0000, 32'h0080_0000, 32'hFFC0_0000, 1'b0, 1'b1);
      mon_on = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule